// File: doc/BRIEF.md
# Interrupt Pending and Priority Controller

This block keeps the interrupt bookkeeping for one interrupt-controller instance. Three 256-bit vectors record which interrupt vectors are requested (pending), which are being serviced (in service), and which were delivered level-triggered. A task priority byte written by software sets a floor. From this byte and the highest in-service vector the block derives a processor priority byte. Only a pending vector whose priority class lies strictly above that byte is offered to the core.

The core takes the offered vector with an acknowledge strobe and retires the highest in-service vector with an end-of-interrupt strobe. When the retired vector was level-triggered, the block emits a one-cycle broadcast pulse carrying the vector, so that the interrupt source can re-arm. Interrupt sources post requests through an accept port. Each request reports back whether it created a new pending entry.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the pending, in-service and trigger vectors and the task priority, and drives every output to 0.
- R2: An accepted request sets the pending bit of `acc_vec`. `acc_new` is 1 in the cycle after the request only when that bit was previously clear. An edge request for an already-pending vector merges and reports `acc_new` = 0.
- R3: A level request (`acc_level` = 1) for a vector that is already pending is dropped, and its trigger bit keeps its old value. Any other accepted request sets the trigger bit for level and clears it for edge, so an edge request over a pending level vector turns it into an edge vector.
- R4: Requests are discarded and `acc_new` stays 0 unless `glb_en` and `sw_en` are both 1.
- R5: The priority class of a byte is that byte with bits 3:0 cleared. `ppr_out` equals the full task priority when the task priority class is at least the class of the highest in-service vector, or when nothing is in service. Otherwise it equals that vector's class.
- R6: `offer_valid` is 1 only when the highest pending vector's class is strictly greater than `ppr_out`. `offer_vec` then carries that vector. Vectors 0 to 15 are stored when accepted but are never offered.
- R7: `ack` while a vector is offered sets that vector's in-service bit and clears its pending bit. `ack` while nothing is offered has no effect.
- R8: `eoi` clears the highest in-service bit and the priority is recomputed. If that vector's trigger bit was set, the trigger bit is cleared and `eoi_bc_valid` pulses for one cycle with `eoi_bc_vec` equal to the vector.
- R9: `eoi` with no in-service bit set changes nothing and gives no broadcast.
- R10: When `ack` and `eoi` arrive in the same cycle, the acknowledge is performed and the end-of-interrupt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable of the controller |
| sw_en | input | 1 | Software enable of the controller |
| acc_valid | input | 1 | Accept-interrupt request strobe |
| acc_vec | input | 8 | Vector of the request |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_new | output | 1 | Pulse: the request created a new pending bit |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 8 | Task priority value to write |
| ack | input | 1 | Acknowledge of the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| offer_valid | output | 1 | A deliverable vector is offered |
| offer_vec | output | 8 | Offered vector (0 when none) |
| ppr_out | output | 8 | Current processor priority byte |
| eoi_bc_valid | output | 1 | Pulse: a level-triggered vector was retired |
| eoi_bc_vec | output | 8 | Vector carried by the broadcast pulse |

## Verification
The pulse outputs `acc_new` and `eoi_bc_valid`/`eoi_bc_vec` are registered at the same clock edge that samples the request. The bench reads them at the falling edge that follows that edge. `offer_valid`, `offer_vec` and `ppr_out` are registered from the stored state. They therefore trail any state change (accept, acknowledge, end-of-interrupt, task priority write) by one further edge, and each scenario waits one extra cycle before sampling them. Stimulus is applied on falling edges, so every sample lands half a cycle away from the edge that produced it.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  // trigger mode carried with each accepted request
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  localparam int DEF_NUM_VEC = 256;
  localparam int DEF_SEG_W   = 32;
  localparam int DEF_RSVD_LO = 16;
  localparam int DEF_CLS_LSB = 4;
endpackage

// File: rtl/vpc_prio_enc.sv
// Highest-set-bit finder, split into segments that are searched in parallel.
// Bits below LO are treated as absent.
module vpc_prio_enc #(
  parameter int W     = 256,
  parameter int SEG_W = 32,
  parameter int LO    = 16,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  localparam int SEG_N  = W / SEG_W;
  localparam int SIDX_W = $clog2(SEG_W);

  logic [SEG_N-1:0]        seg_any;
  logic [SEG_N*SIDX_W-1:0] seg_idx;

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    logic             loc_any;
    logic [SIDX_W-1:0] loc_idx;
    always_comb begin
      loc_any = 1'b0;
      loc_idx = '0;
      for (int b = 0; b < SEG_W; b++) begin
        if (bits[s*SEG_W+b] && ((s*SEG_W+b) >= LO)) begin
          loc_any = 1'b1;
          loc_idx = SIDX_W'(b);
        end
      end
    end
    assign seg_any[s] = loc_any;
    assign seg_idx[s*SIDX_W +: SIDX_W] = loc_idx;
  end

  always_comb begin
    found = |seg_any;
    idx   = '0;
    for (int s = 0; s < SEG_N; s++) begin
      if (seg_any[s]) begin
        idx = IDX_W'(s*SEG_W) + IDX_W'(seg_idx[s*SIDX_W +: SIDX_W]);
      end
    end
  end
endmodule

// File: rtl/vpc_ppr_calc.sv
// Processor priority from task priority and the highest in-service vector.
module vpc_ppr_calc #(
  parameter int VEC_W   = 8,
  parameter int CLS_LSB = 4
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_found,
  input  logic [VEC_W-1:0] isr_top,
  output logic [VEC_W-1:0] ppr
);
  localparam logic [VEC_W-1:0] CLS_MASK = ~VEC_W'((1 << CLS_LSB) - 1);

  logic [VEC_W-1:0] isr_val;
  logic [VEC_W-1:0] tpr_cls;
  logic [VEC_W-1:0] isr_cls;

  always_comb begin
    isr_val = isr_found ? isr_top : '0;
    tpr_cls = tpr & CLS_MASK;
    isr_cls = isr_val & CLS_MASK;
    ppr     = (tpr_cls >= isr_cls) ? tpr : isr_cls;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int NUM_VEC = DEF_NUM_VEC,
  parameter int SEG_W   = DEF_SEG_W,
  parameter int RSVD_LO = DEF_RSVD_LO,
  parameter int CLS_LSB = DEF_CLS_LSB,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en,
  input  logic             sw_en,
  input  logic             acc_valid,
  input  logic [VEC_W-1:0] acc_vec,
  input  logic             acc_level,
  output logic             acc_new,
  input  logic             tpr_wr,
  input  logic [VEC_W-1:0] tpr_data,
  input  logic             ack,
  input  logic             eoi,
  output logic             offer_valid,
  output logic [VEC_W-1:0] offer_vec,
  output logic [VEC_W-1:0] ppr_out,
  output logic             eoi_bc_valid,
  output logic [VEC_W-1:0] eoi_bc_vec
);
  localparam logic [VEC_W-1:0] CLS_MASK = ~VEC_W'((1 << CLS_LSB) - 1);

  // stored state
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [VEC_W-1:0]   tpr_q;

  // next state
  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
  logic               acc_new_n, bc_n;

  // derived
  logic             irr_hit, isr_hit;
  logic [VEC_W-1:0] irr_top, isr_top;
  logic [VEC_W-1:0] ppr_c;
  logic             deliver_c;
  logic             ctl_en;
  logic             ack_take, eoi_take;

  vpc_prio_enc #(.W(NUM_VEC), .SEG_W(SEG_W), .LO(RSVD_LO)) u_irr_enc (
    .bits (irr_q),
    .found(irr_hit),
    .idx  (irr_top)
  );

  vpc_prio_enc #(.W(NUM_VEC), .SEG_W(SEG_W), .LO(RSVD_LO)) u_isr_enc (
    .bits (isr_q),
    .found(isr_hit),
    .idx  (isr_top)
  );

  vpc_ppr_calc #(.VEC_W(VEC_W), .CLS_LSB(CLS_LSB)) u_ppr (
    .tpr      (tpr_q),
    .isr_found(isr_hit),
    .isr_top  (isr_top),
    .ppr      (ppr_c)
  );

  assign ctl_en    = glb_en & sw_en;
  assign deliver_c = irr_hit && ((irr_top & CLS_MASK) > ppr_c);
  assign ack_take  = ack && deliver_c;
  assign eoi_take  = eoi && !ack && isr_hit;

  always_comb begin
    irr_n     = irr_q;
    isr_n     = isr_q;
    tmr_n     = tmr_q;
    acc_new_n = 1'b0;
    bc_n      = 1'b0;
    if (ack_take) begin
      isr_n[irr_top] = 1'b1;
      irr_n[irr_top] = 1'b0;
    end
    if (eoi_take) begin
      isr_n[isr_top] = 1'b0;
      if (tmr_q[isr_top]) begin
        tmr_n[isr_top] = 1'b0;
        bc_n           = 1'b1;
      end
    end
    if (acc_valid && ctl_en) begin
      if (!(irr_q[acc_vec] && acc_level)) begin
        irr_n[acc_vec] = 1'b1;
        tmr_n[acc_vec] = (acc_level == TRIG_LEVEL);
        acc_new_n      = !irr_q[acc_vec];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q        <= '0;
      isr_q        <= '0;
      tmr_q        <= '0;
      tpr_q        <= '0;
      acc_new      <= 1'b0;
      offer_valid  <= 1'b0;
      offer_vec    <= '0;
      ppr_out      <= '0;
      eoi_bc_valid <= 1'b0;
      eoi_bc_vec   <= '0;
    end else begin
      irr_q        <= irr_n;
      isr_q        <= isr_n;
      tmr_q        <= tmr_n;
      if (tpr_wr) tpr_q <= tpr_data;
      acc_new      <= acc_new_n;
      offer_valid  <= deliver_c;
      offer_vec    <= deliver_c ? irr_top : '0;
      ppr_out      <= ppr_c;
      eoi_bc_valid <= bc_n;
      eoi_bc_vec   <= bc_n ? isr_top : '0;
    end
  end
endmodule

// File: rtl/vpc_chk.sv
module vpc_chk #(
  parameter int VEC_W   = 8,
  parameter int RSVD_LO = 16,
  parameter int CLS_LSB = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic             sw_en,
  input logic             acc_valid,
  input logic             eoi,
  input logic             acc_new,
  input logic             offer_valid,
  input logic [VEC_W-1:0] offer_vec,
  input logic [VEC_W-1:0] ppr_out,
  input logic             eoi_bc_valid
);
  localparam logic [VEC_W-1:0] CLS_MASK = ~VEC_W'((1 << CLS_LSB) - 1);

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!offer_valid && ppr_out == '0 && !acc_new && !eoi_bc_valid));

  // R4
  acc_src_chk: assert property (@(posedge clk) disable iff (rst)
    acc_new |-> $past(acc_valid && glb_en && sw_en));

  // R8
  bc_src_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_bc_valid |-> $past(eoi));

  // R6
  offer_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    offer_valid |-> (offer_vec >= VEC_W'(RSVD_LO)));

  // R6
  offer_gate_chk: assert property (@(posedge clk) disable iff (rst)
    offer_valid |-> ((offer_vec & CLS_MASK) > ppr_out));
endmodule

bind irq_prio_ctrl vpc_chk #(.VEC_W(VEC_W), .RSVD_LO(RSVD_LO), .CLS_LSB(CLS_LSB)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .glb_en      (glb_en),
  .sw_en       (sw_en),
  .acc_valid   (acc_valid),
  .eoi         (eoi),
  .acc_new     (acc_new),
  .offer_valid (offer_valid),
  .offer_vec   (offer_vec),
  .ppr_out     (ppr_out),
  .eoi_bc_valid(eoi_bc_valid)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       glb_en = 1'b0, sw_en = 1'b0;
  logic       acc_valid = 1'b0, acc_level = 1'b0;
  logic [7:0] acc_vec = '0;
  logic       acc_new;
  logic       tpr_wr = 1'b0;
  logic [7:0] tpr_data = '0;
  logic       ack = 1'b0, eoi = 1'b0;
  logic       offer_valid;
  logic [7:0] offer_vec, ppr_out, eoi_bc_vec;
  logic       eoi_bc_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .sw_en(sw_en),
    .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
    .acc_new(acc_new), .tpr_wr(tpr_wr), .tpr_data(tpr_data),
    .ack(ack), .eoi(eoi), .offer_valid(offer_valid), .offer_vec(offer_vec),
    .ppr_out(ppr_out), .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vec(eoi_bc_vec)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic accept(input int v, input bit lvl, output bit got_new);
    acc_valid = 1'b1; acc_vec = 8'(v); acc_level = lvl;
    step();
    acc_valid = 1'b0;
    got_new = acc_new;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_eoi(output bit bv, output int bvec);
    eoi = 1'b1; step(); eoi = 1'b0;
    bv = eoi_bc_valid; bvec = int'(eoi_bc_vec);
  endtask

  task automatic wr_tpr(input int t);
    tpr_wr = 1'b1; tpr_data = 8'(t); step(); tpr_wr = 1'b0;
  endtask

  task automatic expect_out(input string req, input bit ov, input int ovec, input int ppr);
    chk(req, "offer_valid", int'(offer_valid), int'(ov));
    chk(req, "offer_vec", int'(offer_vec), ovec);
    chk(req, "ppr_out", int'(ppr_out), ppr);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
    step();
    // R1
    expect_out("R1", 1'b0, 0, 0);
    chk("R1", "acc_new", int'(acc_new), 0);
    chk("R1", "eoi_bc_valid", int'(eoi_bc_valid), 0);
  endtask

  task automatic t_accept_basic();
    bit nw;
    accept(8'h45, 1'b0, nw); chk("R2", "new 45", int'(nw), 1);
    step(); expect_out("R6", 1'b1, 8'h45, 0);
    accept(8'h45, 1'b0, nw); chk("R2", "merge 45", int'(nw), 0);
    accept(8'h80, 1'b1, nw); chk("R2", "new 80", int'(nw), 1);
    step(); expect_out("R6", 1'b1, 8'h80, 0);
  endtask

  task automatic t_ack_eoi();
    bit bv; int bvec;
    do_ack(); step();
    expect_out("R7", 1'b0, 0, 8'h80);   // R5 in-service class wins
    do_eoi(bv, bvec);
    chk("R8", "bc level", int'(bv), 1); chk("R8", "bc vec", bvec, 8'h80);
    step(); expect_out("R8", 1'b1, 8'h45, 0);
    do_ack(); step(); expect_out("R5", 1'b0, 0, 8'h40);
    do_eoi(bv, bvec); chk("R8", "bc edge", int'(bv), 0);
    step(); expect_out("R8", 1'b0, 0, 0);
  endtask

  task automatic t_eoi_empty();
    bit bv; int bvec;
    do_eoi(bv, bvec); chk("R9", "bc empty", int'(bv), 0);
    step(); expect_out("R9", 1'b0, 0, 0);
  endtask

  task automatic t_tpr();
    bit nw, bv; int bvec;
    wr_tpr(8'h53); step(); chk("R5", "ppr tpr", int'(ppr_out), 8'h53);
    accept(8'h60, 1'b0, nw); step(); expect_out("R6", 1'b1, 8'h60, 8'h53);
    do_ack(); step(); chk("R5", "ppr isr cls", int'(ppr_out), 8'h60);
    wr_tpr(8'h7A); step(); chk("R5", "ppr tpr high", int'(ppr_out), 8'h7A);
    do_eoi(bv, bvec); chk("R8", "bc edge 60", int'(bv), 0);
    step(); chk("R5", "ppr after eoi", int'(ppr_out), 8'h7A);
    wr_tpr(8'h50);
    accept(8'h5F, 1'b0, nw); step();
    expect_out("R6", 1'b0, 0, 8'h50);     // equal class not offered
    wr_tpr(8'h4F); step(); expect_out("R6", 1'b1, 8'h5F, 8'h4F);
    wr_tpr(0); do_ack(); do_eoi(bv, bvec); step();
    expect_out("R7", 1'b0, 0, 0);
  endtask

  task automatic t_reserved();
    bit nw;
    accept(8'h0C, 1'b0, nw); chk("R6", "rsvd stored", int'(nw), 1);
    step(); expect_out("R6", 1'b0, 0, 0);
  endtask

  task automatic t_level_repeat();
    bit nw, bv; int bvec;
    accept(8'h90, 1'b1, nw); chk("R3", "new 90", int'(nw), 1);
    accept(8'h90, 1'b1, nw); chk("R3", "drop 90", int'(nw), 0);
    step(); do_ack(); do_eoi(bv, bvec);
    chk("R3", "bc 90", int'(bv), 1); chk("R3", "bc vec 90", bvec, 8'h90);
    accept(8'hA0, 1'b0, nw); chk("R3", "new A0", int'(nw), 1);
    accept(8'hA0, 1'b1, nw); chk("R3", "drop A0", int'(nw), 0);
    step(); do_ack(); do_eoi(bv, bvec); chk("R3", "A0 stays edge", int'(bv), 0);
    accept(8'hB0, 1'b1, nw);
    accept(8'hB0, 1'b0, nw); chk("R3", "merge B0", int'(nw), 0);
    step(); do_ack(); do_eoi(bv, bvec); chk("R3", "B0 now edge", int'(bv), 0);
    step(); expect_out("R3", 1'b0, 0, 0);
  endtask

  task automatic t_disabled();
    bit nw;
    sw_en = 1'b0;
    accept(8'hC0, 1'b0, nw); chk("R4", "sw off", int'(nw), 0);
    sw_en = 1'b1; glb_en = 1'b0;
    accept(8'hC1, 1'b1, nw); chk("R4", "glb off", int'(nw), 0);
    glb_en = 1'b1;
    step(); step(); expect_out("R4", 1'b0, 0, 0);
  endtask

  task automatic t_ack_none();
    bit bv; int bvec;
    do_ack(); step(); expect_out("R7", 1'b0, 0, 0);
    do_eoi(bv, bvec); chk("R7", "ack none no isr", int'(bv), 0);
  endtask

  task automatic t_ack_eoi_same();
    bit nw, bv; int bvec;
    accept(8'hD0, 1'b1, nw); step(); do_ack();
    accept(8'hE0, 1'b0, nw); step(); expect_out("R10", 1'b1, 8'hE0, 8'hD0);
    ack = 1'b1; eoi = 1'b1; step(); ack = 1'b0; eoi = 1'b0;
    chk("R10", "no bc", int'(eoi_bc_valid), 0);
    step(); expect_out("R10", 1'b0, 0, 8'hE0);
    do_eoi(bv, bvec); chk("R10", "E0 edge", int'(bv), 0);
    step(); chk("R8", "ppr back to D0", int'(ppr_out), 8'hD0);
    do_eoi(bv, bvec); chk("R8", "bc D0", int'(bv), 1); chk("R8", "bc vec D0", bvec, 8'hD0);
    step(); chk("R8", "ppr zero", int'(ppr_out), 0);
  endtask

  task automatic t_reset_again();
    bit nw;
    accept(8'h70, 1'b0, nw); step();
    chk("R1", "pre offer", int'(offer_valid), 1);
    rst = 1'b1; step(); rst = 1'b0; step();
    expect_out("R1", 1'b0, 0, 0);
  endtask

  initial begin
    t_reset();
    glb_en = 1'b1; sw_en = 1'b1;
    t_accept_basic();
    t_ack_eoi();
    t_eoi_empty();
    t_tpr();
    t_reserved();
    t_level_repeat();
    t_disabled();
    t_ack_none();
    t_ack_eoi_same();
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule